// File: doc/BRIEF.md
# AXI4-Lite to APB Bridge

This block sits between an AXI4-Lite master and a group of up to sixteen APB peripherals that share one clock and one active-low synchronous reset. It accepts one 32-bit read or write at a time as an AXI4-Lite slave. It decodes the address against a set of power-of-two address windows and replays the access as a two-phase APB transfer toward the one peripheral whose window matches. The peripheral's ready, error and read data return through a per-slave multiplexer, and the bridge answers on the matching AXI response channel.

The control is a single state machine with five states. ST_IDLE accepts a request, with the read taking precedence, and moves to ST_SETUP. ST_SETUP drives the select with the enable low. From there it moves to ST_ACCESS when a window matched, or straight to ST_RRESP / ST_BRESP when none did. ST_ACCESS holds the enable high until the slave is ready or the optional data-phase watchdog expires, then moves to ST_RRESP (read) or ST_BRESP (write). Each response state holds its valid until the master takes it, then returns to ST_IDLE. A parameter chooses APB4 mode, in which write strobes and protection bits are forwarded, or APB3 mode, in which both stay zero.

Top module: `axil_apb_bridge`

## Requirements
- R1: While reset is applied and after it is released with no request, every output is zero, including AWREADY, WREADY, ARREADY, BVALID, RVALID, PSEL and PENABLE.
- R2: Each APB transfer spends exactly one cycle with PSEL set and PENABLE low, followed by access cycles with PENABLE high. During those cycles PSEL, PADDR, PWRITE and PWDATA stay stable until PREADY of the selected slave is high. With PREADY high in the k-th access cycle, PENABLE is high for exactly k cycles.
- R3: Slave i owns the addresses from its base to its high address inclusive (a power-of-two size of at least 4 KB, with the base aligned to that size). An access inside that window raises only PSEL bit i. PADDR equals the AXI address and PWDATA equals WDATA, both unchanged.
- R4: RDATA, the completion and the error come only from the selected slave. The PREADY, PSLVERR and PRDATA of unselected slaves have no effect.
- R5: A transfer that ends with the selected slave's PSLVERR high answers SLVERR (2'b10) on RRESP or BRESP. Every other completion answers OKAY (2'b00). The codes 2'b01 and 2'b11 never appear.
- R6: When ARVALID, AWVALID and WVALID are all high in the same idle cycle, the read is carried out on APB first. The write follows after the read response has been taken.
- R7: An address that lies in no window raises no PSEL bit and makes no APB transfer. It completes with OKAY and, for a read, all-zero RDATA.
- R8: With the timeout set to T (16, 32, 64, 128 or 256), an access whose PREADY stays low for T access cycles ends after the T-th one. It answers OKAY, with zero RDATA for a read, whatever PSLVERR shows. If PREADY is high in the T-th cycle, the transfer completes normally. T = 0 disables the watchdog.
- R9: In APB4 mode, PSTRB carries WSTRB for writes and is zero for reads, and PPROT carries AWPROT for writes and ARPROT for reads. In APB3 mode, PSTRB and PPROT are always zero.
- R10: When ARVALID is first sampled high with the bridge idle, the window hits and the slave is ready in its first access cycle, RVALID goes high at the third rising edge counting that sampling edge.
- R11: Only one transaction is in flight. The AXI ready outputs pulse only for a request taken from ST_IDLE. RVALID or BVALID stays high, with stable data and response, until RREADY or BREADY is seen. RVALID and BVALID are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| awaddr | input | 32 | Write address |
| awprot | input | 3 | Write protection attributes |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte enables |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Master takes the write response |
| araddr | input | 32 | Read address |
| arprot | input | 3 | Read protection attributes |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Master takes the read data |
| paddr | output | 32 | APB address |
| pprot | output | 3 | APB protection attributes |
| psel | output | NUM_SLV | One-hot slave select |
| penable | output | 1 | APB access phase |
| pwrite | output | 1 | APB direction, high for write |
| pwdata | output | 32 | APB write data |
| pstrb | output | 4 | APB write byte enables |
| pready | input | NUM_SLV | Per-slave ready |
| prdata | input | NUM_SLV*32 | Per-slave read data, slave i in bits 32*i+31 down to 32*i |
| pslverr | input | NUM_SLV | Per-slave error |

## Verification
The bench builds the main instance with three slaves whose windows are 4 KB at 0x0, 8 KB at 0x2000 and 64 KB at 0x10000, with APB4 mode and a 16-cycle timeout. This leaves gaps at 0x1000 and from 0x4000 to 0xFFFF. A sweep over all 32 pages below 0x20000, reading and writing, therefore reaches every window, both gaps and the non-matching slaves that drive hostile ready, error and data values. Wait states of 15 and of 100 cycles place the transfer on each side of the watchdog limit. A second instance, in APB3 mode with the watchdog disabled, runs alongside on the same requests to show that its strobes and protection bits stay at zero and that the disabled timer variant elaborates.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int STRB_W     = DATA_W / 8;
    localparam int PROT_W     = 3;
    localparam int MAX_SLV    = 16;
    localparam int PAGE_BYTES = 4096;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_BRESP,
        ST_RRESP
    } brg_state_e;

    typedef logic [1:0] resp_t;
    localparam resp_t RESP_OKAY   = 2'b00;
    localparam resp_t RESP_SLVERR = 2'b10;

    // Default windows: slave i owns page i (4 KB each).
    function automatic logic [MAX_SLV*ADDR_W-1:0] page_windows(input bit upper);
        logic [MAX_SLV*ADDR_W-1:0] v;
        v = '0;
        for (int i = 0; i < MAX_SLV; i++) begin
            v[i*ADDR_W +: ADDR_W] = ADDR_W'(i * PAGE_BYTES + (upper ? PAGE_BYTES - 1 : 0));
        end
        return v;
    endfunction

    localparam logic [MAX_SLV*ADDR_W-1:0] DFLT_BASE = page_windows(1'b0);
    localparam logic [MAX_SLV*ADDR_W-1:0] DFLT_HIGH = page_windows(1'b1);

endpackage

// File: rtl/win_decoder.sv
module win_decoder
    import bridge_pkg::*;
#(
    parameter int NUM_SLV = 4,
    parameter logic [MAX_SLV*ADDR_W-1:0] WIN_BASE = DFLT_BASE,
    parameter logic [MAX_SLV*ADDR_W-1:0] WIN_HIGH = DFLT_HIGH
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_SLV-1:0] hit_o
);

    logic [NUM_SLV-1:0] raw_hit;

    for (genvar i = 0; i < NUM_SLV; i++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = WIN_BASE[i*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HIGH = WIN_HIGH[i*ADDR_W +: ADDR_W];
        // Window size is a power of two with an aligned base, so a mask test suffices.
        localparam logic [ADDR_W-1:0] MASK = ~(HIGH - BASE);
        assign raw_hit[i] = ((addr_i & MASK) == BASE);
    end

    // Keep only the lowest matching slave so the select stays one-hot.
    assign hit_o = raw_hit & (~raw_hit + NUM_SLV'(1));

endmodule

// File: rtl/slave_mux.sv
module slave_mux
    import bridge_pkg::*;
#(
    parameter int NUM_SLV = 4
) (
    input  logic [NUM_SLV-1:0]        sel_i,
    input  logic [NUM_SLV-1:0]        pready_i,
    input  logic [NUM_SLV-1:0]        pslverr_i,
    input  logic [NUM_SLV*DATA_W-1:0] prdata_i,
    output logic                      ready_o,
    output logic                      err_o,
    output logic [DATA_W-1:0]         rdata_o
);

    logic [DATA_W-1:0] masked [NUM_SLV];

    for (genvar i = 0; i < NUM_SLV; i++) begin : g_mask
        assign masked[i] = prdata_i[i*DATA_W +: DATA_W] & {DATA_W{sel_i[i]}};
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SLV; i++) begin
            rdata_o = rdata_o | masked[i];
        end
    end

    assign ready_o = |(sel_i & pready_i);
    assign err_o   = |(sel_i & pslverr_i);

endmodule

// File: rtl/dphase_timer.sv
module dphase_timer #(
    parameter int LIMIT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic stall_i,
    output logic expired_o
);

    if (LIMIT == 0) begin : g_off
        logic unused_tmr;
        assign unused_tmr = ^{clk, rst_n, clear_i, stall_i};
        assign expired_o  = 1'b0;
    end else begin : g_on
        localparam int CW = $clog2(LIMIT);
        localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                cnt_q <= '0;
            end else if (stall_i && cnt_q != LAST) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end

        assign expired_o = stall_i && (cnt_q == LAST);
    end

endmodule

// File: rtl/axil_apb_bridge.sv
module axil_apb_bridge
    import bridge_pkg::*;
#(
    parameter int NUM_SLV = 4,
    parameter bit APB4    = 1'b1,
    parameter int TIMEOUT = 0,
    parameter logic [MAX_SLV*ADDR_W-1:0] WIN_BASE = DFLT_BASE,
    parameter logic [MAX_SLV*ADDR_W-1:0] WIN_HIGH = DFLT_HIGH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         awaddr,
    input  logic [PROT_W-1:0]         awprot,
    input  logic                      awvalid,
    output logic                      awready,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [STRB_W-1:0]         wstrb,
    input  logic                      wvalid,
    output logic                      wready,
    output logic [1:0]                bresp,
    output logic                      bvalid,
    input  logic                      bready,
    input  logic [ADDR_W-1:0]         araddr,
    input  logic [PROT_W-1:0]         arprot,
    input  logic                      arvalid,
    output logic                      arready,
    output logic [DATA_W-1:0]         rdata,
    output logic [1:0]                rresp,
    output logic                      rvalid,
    input  logic                      rready,
    output logic [ADDR_W-1:0]         paddr,
    output logic [PROT_W-1:0]         pprot,
    output logic [NUM_SLV-1:0]        psel,
    output logic                      penable,
    output logic                      pwrite,
    output logic [DATA_W-1:0]         pwdata,
    output logic [STRB_W-1:0]         pstrb,
    input  logic [NUM_SLV-1:0]        pready,
    input  logic [NUM_SLV*DATA_W-1:0] prdata,
    input  logic [NUM_SLV-1:0]        pslverr
);

    brg_state_e state_q, state_d;

    logic               take_rd, take_wr;
    logic [ADDR_W-1:0]  req_addr;
    logic [NUM_SLV-1:0] req_hit;
    logic               sel_ready, sel_err;
    logic [DATA_W-1:0]  sel_rdata;
    logic               wd_expired;
    logic               access_done;
    resp_t              done_resp;

    // Read wins when both a read and a complete write are pending.
    assign take_rd  = arvalid;
    assign take_wr  = !arvalid && awvalid && wvalid;
    assign req_addr = take_rd ? araddr : awaddr;

    win_decoder #(
        .NUM_SLV  (NUM_SLV),
        .WIN_BASE (WIN_BASE),
        .WIN_HIGH (WIN_HIGH)
    ) u_dec (
        .addr_i (req_addr),
        .hit_o  (req_hit)
    );

    slave_mux #(
        .NUM_SLV (NUM_SLV)
    ) u_mux (
        .sel_i     (psel),
        .pready_i  (pready),
        .pslverr_i (pslverr),
        .prdata_i  (prdata),
        .ready_o   (sel_ready),
        .err_o     (sel_err),
        .rdata_o   (sel_rdata)
    );

    dphase_timer #(
        .LIMIT (TIMEOUT)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (state_q == ST_SETUP),
        .stall_i   (state_q == ST_ACCESS && !sel_ready),
        .expired_o (wd_expired)
    );

    assign access_done = sel_ready || wd_expired;
    assign done_resp   = (sel_ready && sel_err) ? RESP_SLVERR : RESP_OKAY;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_rd || take_wr) begin
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (|psel) begin
                    state_d = ST_ACCESS;
                end else begin
                    state_d = pwrite ? ST_BRESP : ST_RRESP;
                end
            end
            ST_ACCESS: begin
                if (access_done) begin
                    state_d = pwrite ? ST_BRESP : ST_RRESP;
                end
            end
            ST_BRESP: begin
                if (bready) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RRESP: begin
                if (rready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awready <= 1'b0;
            wready  <= 1'b0;
            arready <= 1'b0;
            bvalid  <= 1'b0;
            bresp   <= RESP_OKAY;
            rvalid  <= 1'b0;
            rresp   <= RESP_OKAY;
            rdata   <= '0;
            paddr   <= '0;
            pprot   <= '0;
            psel    <= '0;
            penable <= 1'b0;
            pwrite  <= 1'b0;
            pwdata  <= '0;
            pstrb   <= '0;
        end else begin
            awready <= 1'b0;
            wready  <= 1'b0;
            arready <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take_rd) begin
                        arready <= 1'b1;
                        paddr   <= araddr;
                        pprot   <= APB4 ? arprot : '0;
                        pstrb   <= '0;
                        pwrite  <= 1'b0;
                        psel    <= req_hit;
                    end else if (take_wr) begin
                        awready <= 1'b1;
                        wready  <= 1'b1;
                        paddr   <= awaddr;
                        pprot   <= APB4 ? awprot : '0;
                        pstrb   <= APB4 ? wstrb : '0;
                        pwdata  <= wdata;
                        pwrite  <= 1'b1;
                        psel    <= req_hit;
                    end
                end
                ST_SETUP: begin
                    if (|psel) begin
                        penable <= 1'b1;
                    end else if (pwrite) begin
                        bvalid <= 1'b1;
                        bresp  <= RESP_OKAY;
                    end else begin
                        rvalid <= 1'b1;
                        rresp  <= RESP_OKAY;
                        rdata  <= '0;
                    end
                end
                ST_ACCESS: begin
                    if (access_done) begin
                        penable <= 1'b0;
                        psel    <= '0;
                        if (pwrite) begin
                            bvalid <= 1'b1;
                            bresp  <= done_resp;
                        end else begin
                            rvalid <= 1'b1;
                            rresp  <= done_resp;
                            rdata  <= sel_ready ? sel_rdata : '0;
                        end
                    end
                end
                ST_BRESP: begin
                    if (bready) begin
                        bvalid <= 1'b0;
                    end
                end
                ST_RRESP: begin
                    if (rready) begin
                        rvalid <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/axil_apb_bridge_chk.sv
module axil_apb_bridge_chk
    import bridge_pkg::*;
#(
    parameter int NUM_SLV = 4,
    parameter bit APB4    = 1'b1,
    parameter int TIMEOUT = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 awready,
    input logic                 arready,
    input logic                 bvalid,
    input logic                 bready,
    input logic [1:0]           bresp,
    input logic                 rvalid,
    input logic                 rready,
    input logic [1:0]           rresp,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_SLV-1:0]   psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [ADDR_W-1:0]    paddr,
    input logic [DATA_W-1:0]    pwdata,
    input logic [STRB_W-1:0]    pstrb,
    input logic [PROT_W-1:0]    pprot,
    input logic [NUM_SLV-1:0]   pready
);

    logic       slv_rdy;
    logic [8:0] stall_cnt;
    logic       last_tick;

    assign slv_rdy = (psel & pready) != '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cnt <= '0;
        end else if (penable && !slv_rdy) begin
            if (stall_cnt != 9'h1FF) stall_cnt <= stall_cnt + 9'd1;
        end else begin
            stall_cnt <= '0;
        end
    end

    assign last_tick = (TIMEOUT != 0) && (stall_cnt == 9'(TIMEOUT - 1));

    p_setup_then_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel != '0 && !penable) |=> penable);

    p_enable_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> (psel != '0));

    p_stable_in_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && !slv_rdy && !last_tick) |=>
            (penable && $stable(psel) && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(psel));

    p_rresp_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rresp == RESP_OKAY || rresp == RESP_SLVERR));

    p_bresp_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == RESP_OKAY || bresp == RESP_SLVERR));

    p_timeout_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && TIMEOUT != 0) |-> (stall_cnt < 9'(TIMEOUT)));

    p_read_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel != '0 && !pwrite) |-> (pstrb == '0));

    p_apb3_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!APB4) |-> (pstrb == '0 && pprot == '0));

    p_rvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)));

    p_bvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp)));

    p_ready_when_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arready || awready) |-> (!rvalid && !bvalid && !penable));

    p_single_response_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid && bvalid));

endmodule

bind axil_apb_bridge axil_apb_bridge_chk #(
    .NUM_SLV (NUM_SLV),
    .APB4    (APB4),
    .TIMEOUT (TIMEOUT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .awready (awready),
    .arready (arready),
    .bvalid  (bvalid),
    .bready  (bready),
    .bresp   (bresp),
    .rvalid  (rvalid),
    .rready  (rready),
    .rresp   (rresp),
    .rdata   (rdata),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .pstrb   (pstrb),
    .pprot   (pprot),
    .pready  (pready)
);

// File: tb/axil_apb_bridge_test.sv
`timescale 1ns/1ps
module axil_apb_bridge_test;
    import bridge_pkg::*;

    localparam int NS  = 3;
    localparam int TMO = 16;
    localparam logic [MAX_SLV*ADDR_W-1:0] TB_BASE =
        {{((MAX_SLV-NS)*ADDR_W){1'b0}}, 32'h0001_0000, 32'h0000_2000, 32'h0000_0000};
    localparam logic [MAX_SLV*ADDR_W-1:0] TB_HIGH =
        {{((MAX_SLV-NS)*ADDR_W){1'b0}}, 32'h0001_FFFF, 32'h0000_3FFF, 32'h0000_0FFF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] awaddr = '0, wdata = '0, araddr = '0;
    logic [2:0]  awprot = '0, arprot = '0;
    logic [3:0]  wstrb = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic        bready = 1'b1, rready = 1'b1;

    logic        awready, wready, bvalid, arready, rvalid, penable, pwrite;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata, paddr, pwdata;
    logic [2:0]  pprot;
    logic [3:0]  pstrb;
    logic [NS-1:0] psel, pready_v, pslverr_v;
    logic [NS*32-1:0] prdata_v;

    logic        awready3, wready3, bvalid3, arready3, rvalid3, penable3, pwrite3;
    logic [1:0]  bresp3, rresp3;
    logic [31:0] rdata3, paddr3, pwdata3;
    logic [2:0]  pprot3;
    logic [3:0]  pstrb3;
    logic [NS-1:0] psel3;

    int  n_chk = 0, n_err = 0, cyc = 0;
    bit  done = 1'b0;
    int  wait_n = 0;
    bit  model_err = 1'b0;
    int  acc = 0;
    logic model_rdy;

    function automatic logic [31:0] slv_word(input int i, input logic [31:0] a);
        return {4'(i + 1), a[27:0]};
    endfunction

    function automatic int exp_slave(input logic [31:0] a);
        if (a <= 32'h0000_0FFF) return 0;
        if (a >= 32'h0000_2000 && a <= 32'h0000_3FFF) return 1;
        if (a >= 32'h0001_0000 && a <= 32'h0001_FFFF) return 2;
        return -1;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) acc <= penable ? acc + 1 : 0;
    assign model_rdy = penable && (acc >= wait_n);

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            prdata_v[i*32 +: 32] = psel[i] ? slv_word(i, paddr) : 32'hDEAD_BEEF;
            pready_v[i]  = psel[i] ? model_rdy : 1'b1;
            pslverr_v[i] = psel[i] ? (model_err && model_rdy) : 1'b1;
        end
    end

    axil_apb_bridge #(.NUM_SLV(NS), .APB4(1'b1), .TIMEOUT(TMO),
                      .WIN_BASE(TB_BASE), .WIN_HIGH(TB_HIGH)) uut (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awprot(awprot), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arprot(arprot), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .paddr(paddr), .pprot(pprot), .psel(psel), .penable(penable), .pwrite(pwrite),
        .pwdata(pwdata), .pstrb(pstrb), .pready(pready_v), .prdata(prdata_v), .pslverr(pslverr_v));

    axil_apb_bridge #(.NUM_SLV(NS), .APB4(1'b0), .TIMEOUT(0),
                      .WIN_BASE(TB_BASE), .WIN_HIGH(TB_HIGH)) uut_p3 (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awprot(awprot), .awvalid(awvalid), .awready(awready3),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready3),
        .bresp(bresp3), .bvalid(bvalid3), .bready(bready),
        .araddr(araddr), .arprot(arprot), .arvalid(arvalid), .arready(arready3),
        .rdata(rdata3), .rresp(rresp3), .rvalid(rvalid3), .rready(rready),
        .paddr(paddr3), .pprot(pprot3), .psel(psel3), .penable(penable3), .pwrite(pwrite3),
        .pwdata(pwdata3), .pstrb(pstrb3), .pready({NS{1'b1}}), .prdata({(NS*32){1'b0}}),
        .pslverr({NS{1'b0}}));

    // APB monitors, sampled mid-cycle
    int          en_cycles = 0, log_n = 0, p3_wr = 0;
    bit          p3_bad = 1'b0;
    logic        lg_wr   [8];
    logic [31:0] lg_addr [8];
    logic [31:0] lg_data [8];
    logic [3:0]  lg_strb [8];
    logic [2:0]  lg_prot [8];
    logic [NS-1:0] lg_sel [8];

    always @(negedge clk) begin
        if (rst_n) begin
            if (penable) en_cycles <= en_cycles + 1;
            if (penable && (psel & pready_v) != '0) begin
                lg_wr[log_n % 8]   <= pwrite;
                lg_addr[log_n % 8] <= paddr;
                lg_data[log_n % 8] <= pwdata;
                lg_strb[log_n % 8] <= pstrb;
                lg_prot[log_n % 8] <= pprot;
                lg_sel[log_n % 8]  <= psel;
                log_n <= log_n + 1;
            end
            if (psel3 != '0 && (pstrb3 != '0 || pprot3 != '0)) p3_bad <= 1'b1;
            if (psel3 != '0 && penable3 && pwrite3) p3_wr <= p3_wr + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] a, input logic [2:0] prot, input int w,
                           input bit e, input int hold,
                           output logic [31:0] d, output logic [1:0] r, output int lat);
        int t0;
        wait_n = w; model_err = e;
        rready = (hold == 0);
        @(negedge clk);
        araddr = a; arprot = prot; arvalid = 1'b1; t0 = cyc;
        do @(negedge clk); while (!arready);
        @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        lat = cyc - t0; d = rdata; r = rresp;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R11 rvalid held", {31'd0, rvalid}, 32'd1);
            chk("R11 rdata stable", rdata, d);
        end
        rready = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] dat, input logic [3:0] st,
                            input logic [2:0] prot, input int w, input bit e,
                            output logic [1:0] r);
        wait_n = w; model_err = e; bready = 1'b1;
        @(negedge clk);
        awaddr = a; wdata = dat; wstrb = st; awprot = prot; awvalid = 1'b1; wvalid = 1'b1;
        do @(negedge clk); while (!awready);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        while (!bvalid) @(negedge clk);
        r = bresp;
        @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a, dat;
        logic [1:0]  r;
        int lat, es, l0, e0;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 ready outputs", {29'd0, awready, wready, arready}, 32'd0);
        chk("R1 valid outputs", {30'd0, bvalid, rvalid}, 32'd0);
        chk("R1 apb select", {28'd0, penable, psel}, 32'd0);
        chk("R1 apb buses", paddr | pwdata | rdata | {25'd0, pprot, pstrb}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after release", {26'd0, awready, wready, arready, bvalid, rvalid, penable}, 32'd0);

        // R10 latency
        do_read(32'h0000_0104, 3'd0, 0, 1'b0, 0, d, r, lat);
        chk("R10 read latency", lat, 32'd3);
        chk("R3 read data", d, slv_word(0, 32'h0000_0104));

        // Page sweep: every window and gap, read then write
        for (int pg = 0; pg < 32; pg++) begin
            a  = (pg << 12) | ((pg * 52) & 32'hFFC);
            es = exp_slave(a);
            l0 = log_n;
            e0 = en_cycles;
            do_read(a, 3'(pg % 8), pg % 3, (pg % 5) == 0, 0, d, r, lat);
            chk($sformatf("R4 read data page %0d", pg), d, (es >= 0) ? slv_word(es, a) : 32'd0);
            chk($sformatf("R5 rresp page %0d", pg), {30'd0, r},
                (es >= 0 && (pg % 5) == 0) ? 32'd2 : 32'd0);
            chk($sformatf("R7 transfer count page %0d", pg), log_n - l0, (es >= 0) ? 32'd1 : 32'd0);
            if (es >= 0) begin
                chk($sformatf("R3 read sel page %0d", pg), {29'd0, lg_sel[l0 % 8]}, 32'(1 << es));
                chk($sformatf("R3 read addr page %0d", pg), lg_addr[l0 % 8], a);
                chk($sformatf("R9 read prot page %0d", pg), {29'd0, lg_prot[l0 % 8]}, 32'(pg % 8));
                chk($sformatf("R9 read strobe page %0d", pg), {28'd0, lg_strb[l0 % 8]}, 32'd0);
                chk($sformatf("R2 access cycles page %0d", pg), en_cycles - e0, 32'(pg % 3 + 1));
            end

            dat = 32'(pg) * 32'h0101_0101 ^ 32'hA5A5_0000;
            l0 = log_n;
            do_write(a, dat, 4'(pg), 3'(7 - pg % 8), (pg + 1) % 3, (pg % 4) == 1, r);
            chk($sformatf("R5 bresp page %0d", pg), {30'd0, r},
                (es >= 0 && (pg % 4) == 1) ? 32'd2 : 32'd0);
            chk($sformatf("R7 write count page %0d", pg), log_n - l0, (es >= 0) ? 32'd1 : 32'd0);
            if (es >= 0) begin
                chk($sformatf("R3 write sel page %0d", pg), {29'd0, lg_sel[l0 % 8]}, 32'(1 << es));
                chk($sformatf("R3 write addr page %0d", pg), lg_addr[l0 % 8], a);
                chk($sformatf("R3 write data page %0d", pg), lg_data[l0 % 8], dat);
                chk($sformatf("R3 write dir page %0d", pg), {31'd0, lg_wr[l0 % 8]}, 32'd1);
                chk($sformatf("R9 write strobe page %0d", pg), {28'd0, lg_strb[l0 % 8]}, 32'(pg % 16));
                chk($sformatf("R9 write prot page %0d", pg), {29'd0, lg_prot[l0 % 8]}, 32'(7 - pg % 8));
            end
        end

        // R8 timeout: stalled read, stalled read with error, last-cycle ready, stalled write
        l0 = log_n; e0 = en_cycles;
        do_read(32'h0001_0040, 3'd0, 100, 1'b0, 0, d, r, lat);
        chk("R8 timeout access cycles", en_cycles - e0, TMO);
        chk("R8 timeout rdata", d, 32'd0);
        chk("R8 timeout rresp", {30'd0, r}, 32'd0);
        chk("R8 timeout no completion", log_n - l0, 32'd0);
        do_read(32'h0000_2040, 3'd0, 100, 1'b1, 0, d, r, lat);
        chk("R8 timeout ignores error", {30'd0, r}, 32'd0);
        e0 = en_cycles;
        do_read(32'h0000_2080, 3'd0, TMO - 1, 1'b1, 0, d, r, lat);
        chk("R8 ready on last cycle data", d, slv_word(1, 32'h0000_2080));
        chk("R8 ready on last cycle resp", {30'd0, r}, 32'd2);
        chk("R8 ready on last cycle cycles", en_cycles - e0, TMO);
        do_write(32'h0000_0200, 32'h1234_5678, 4'hF, 3'd1, 100, 1'b1, r);
        chk("R8 write timeout bresp", {30'd0, r}, 32'd0);

        // R11 response held while rready low
        do_read(32'h0000_0300, 3'd2, 1, 1'b0, 5, d, r, lat);
        chk("R11 held read data", d, slv_word(0, 32'h0000_0300));

        // R6 simultaneous read and write
        begin
            bit drop_ar, drop_aw, got_r, got_b;
            logic [31:0] rd;
            drop_ar = 0; drop_aw = 0; got_r = 0; got_b = 0; rd = '0;
            wait_n = 1; model_err = 0; rready = 1; bready = 1;
            l0 = log_n;
            @(negedge clk);
            araddr = 32'h0000_0010; arprot = 3'd0; arvalid = 1'b1;
            awaddr = 32'h0000_2010; wdata = 32'hCAFE_0001; wstrb = 4'h3; awprot = 3'd0;
            awvalid = 1'b1; wvalid = 1'b1;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (drop_ar) begin arvalid = 1'b0; drop_ar = 0; end
                if (drop_aw) begin awvalid = 1'b0; wvalid = 1'b0; drop_aw = 0; end
                if (arready) drop_ar = 1;
                if (awready) drop_aw = 1;
                if (rvalid && !got_r) begin got_r = 1; rd = rdata; end
                if (bvalid) got_b = 1;
            end
            chk("R6 both completed", {30'd0, got_r, got_b}, 32'd3);
            chk("R6 two transfers", log_n - l0, 32'd2);
            chk("R6 read first", {31'd0, lg_wr[l0 % 8]}, 32'd0);
            chk("R6 write second", {31'd0, lg_wr[(l0 + 1) % 8]}, 32'd1);
            chk("R6 write addr", lg_addr[(l0 + 1) % 8], 32'h0000_2010);
            chk("R6 read data", rd, slv_word(0, 32'h0000_0010));
        end

        // R9 APB3 instance quiet
        chk("R9 apb3 strobe and prot zero", {31'd0, p3_bad}, 32'd0);
        chk("R9 apb3 writes seen", {31'd0, p3_wr > 10}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule